// File: doc/BRIEF.md
# Compare-Channel Timer/Counter

This block is a word-addressed timer/counter with four compare channels. Software selects one of two count sources. In timer mode the counter advances on a tick enable, which the block derives by dividing the block clock by a power of two. In counter mode the counter advances once for every write to the count task. Each channel holds a compare value. When the counter advances onto that value, the channel raises a flag that stays set until software clears it. Per-channel shortcut bits can also zero the counter or halt the timer at that moment.

The block is used as a register-mapped peripheral. Task addresses act only when the value 1 is written to them. Configuration registers read back their stored values. A capture task copies the live count into a compare register, and this is the way software samples the counter. A single level interrupt combines the compare flags with the enable bits. The block clock plays the role of the 16 MHz base clock, so in timer mode the tick rate is that clock divided by 2^psc.

The bus is a plain control interface, not a stream. A write takes effect at the clock edge on which `bus_wr` is high. The read data is combinational from `bus_addr`. The bus has no back-pressure: every access completes in one cycle.

Top module: `tmr_ccu`

## Requirements
- R1: After reset the counter, all compare values, all flags, the shortcut, enable, mode, width and psc registers read 0, the timer is halted and `irq_o` is 0.
- R2: In timer mode, once running, the counter advances once every 2^psc clock cycles, with the divider restarted by START and CLEAR. A psc write above 9 stores 9 (psc address 22, 4-bit field).
- R3: The width code at address 21 selects the counter size: 0 gives 16 bits, 1 gives 8, 2 gives 24, 3 gives 32. The counter wraps to 0 modulo 2^size.
- R4: A value written to compare register i (address 16+i) is stored modulo 2^size of the current width.
- R5: When the counter advances to a value equal to compare i, flag i (address 12+i) becomes 1. The flag stays 1 until a write of 0 to its address. A write of any other value leaves it unchanged.
- R6: Shortcut bit i (address 5) makes a compare on channel i load 0 into the counter instead of the compared value.
- R7: Shortcut bit 8+i makes a compare on channel i halt the timer, which keeps the compared count.
- R8: `irq_o` is 1 exactly when some flag i is 1 together with enable bit 16+i.
- R9: A write to address 6 ORs bits 19:16 of the data into the enable register. A write to address 7 clears the enable bits written as 1. Both addresses read the enable register.
- R10: START (address 0) runs the timer only in timer mode (mode address 20: 0 timer, 1 counter). COUNT (address 2) advances the counter only in counter mode. STOP (address 1) and HALT (address 4) stop the timer.
- R11: CAPTURE i (address 8+i) copies the current counter into compare i. CLEAR (address 3) sets the counter to 0.
- R12: A task address written with any value other than 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (tick base) |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that every state change comes through the bus: at most one write per cycle, and reset held for at least one edge. From that they conclude that a flag can only fall after a zero write to its own address, and that the timer can only halt after a stop-type task or a stop shortcut. They also assume that the width code is not changed while the counter runs, since a narrower width would leave the old count out of range. The stimulus keeps within this: it drives one write at a time between falling edges, changes the width only while the counter is halted or in counter mode, and resets the block before each directed scenario.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int NUM_CH  = 4;
  parameter int CNT_W   = 32;
  parameter int PSC_W   = 4;
  parameter int PSC_MAX = 9;
  parameter int ADDR_W  = 5;

  localparam logic [ADDR_W-1:0] A_START   = 5'd0;
  localparam logic [ADDR_W-1:0] A_STOP    = 5'd1;
  localparam logic [ADDR_W-1:0] A_COUNT   = 5'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR   = 5'd3;
  localparam logic [ADDR_W-1:0] A_HALT    = 5'd4;
  localparam logic [ADDR_W-1:0] A_SHORT   = 5'd5;
  localparam logic [ADDR_W-1:0] A_EN_SET  = 5'd6;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 5'd7;
  localparam logic [ADDR_W-1:0] A_CAP0    = 5'd8;
  localparam logic [ADDR_W-1:0] A_FLAG0   = 5'd12;
  localparam logic [ADDR_W-1:0] A_CMP0    = 5'd16;
  localparam logic [ADDR_W-1:0] A_MODE    = 5'd20;
  localparam logic [ADDR_W-1:0] A_WIDTH   = 5'd21;
  localparam logic [ADDR_W-1:0] A_PSC     = 5'd22;

  localparam int EN_LSB   = 16;
  localparam int STOP_LSB = 8;

  typedef enum logic {SRC_TIMER = 1'b0, SRC_COUNT = 1'b1} src_e;

  function automatic logic [CNT_W-1:0] cnt_mask(input logic [1:0] sel);
    logic [31:0] m;
    case (sel)
      2'd0: m = 32'h0000_FFFF;
      2'd1: m = 32'h0000_00FF;
      2'd2: m = 32'h00FF_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PSC_W   = tmr_pkg::PSC_W,
  parameter int PSC_MAX = tmr_pkg::PSC_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  localparam int DIV_W = PSC_MAX + 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = DIV_W'((1 << psc) - 1);
  assign tick  = en && (div_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)            div_q <= '0;
    else if (restart)      div_q <= '0;
    else if (en) begin
      if (div_q == limit)  div_q <= '0;
      else                 div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = tmr_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             cap,
  input  logic [CNT_W-1:0] cnt_cur,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cmp_q,
  output logic             flag_q,
  output logic             hit
);
  assign hit = adv && (cnt_nxt == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap)         cmp_q <= cnt_cur;
      else if (cmp_wr) cmp_q <= cmp_wdata;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu
  import tmr_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int CW  = CNT_W,
  parameter int AW  = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o
);
  logic              trig;
  logic              t_start, t_stop, t_count, t_clear, t_halt;
  logic [NCH-1:0]    t_cap, cmp_wr, flag_clr, hit, flag_q;
  logic [CW-1:0]     cmp_q [NCH];
  logic [CW-1:0]     cnt_q, cnt_nxt, mask;
  logic [NCH-1:0]    sc_clr_q, sc_stop_q, en_q;
  logic              run_q, tick, adv, clr_hit, stop_hit;
  src_e              mode_q;
  logic [1:0]        width_q;
  logic [PSC_W-1:0]  psc_q;

  assign trig    = bus_wr && (bus_wdata == 32'd1);
  assign t_start = trig && bus_addr == A_START && mode_q == SRC_TIMER;
  assign t_stop  = trig && bus_addr == A_STOP;
  assign t_count = trig && bus_addr == A_COUNT && mode_q == SRC_COUNT;
  assign t_clear = trig && bus_addr == A_CLEAR;
  assign t_halt  = trig && bus_addr == A_HALT;

  assign mask     = cnt_mask(width_q);
  assign cnt_nxt  = (cnt_q + 1'b1) & mask;
  assign adv      = (mode_q == SRC_TIMER && tick) || t_count;
  assign clr_hit  = |(hit & sc_clr_q);
  assign stop_hit = |(hit & sc_stop_q);
  assign irq_o    = |(flag_q & en_q);

  tmr_tick_gen u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (run_q && mode_q == SRC_TIMER),
    .restart (t_start || t_clear),
    .psc     (psc_q),
    .tick    (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign t_cap[i]    = trig && bus_addr == AW'(A_CAP0 + i);
    assign cmp_wr[i]   = bus_wr && bus_addr == AW'(A_CMP0 + i);
    assign flag_clr[i] = bus_wr && bus_addr == AW'(A_FLAG0 + i) && bus_wdata == 32'd0;
    tmr_chan #(.CNT_W(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_wr    (cmp_wr[i]),
      .cmp_wdata (bus_wdata[CW-1:0] & mask),
      .cap       (t_cap[i]),
      .cnt_cur   (cnt_q),
      .adv       (adv),
      .cnt_nxt   (cnt_nxt),
      .flag_clr  (flag_clr[i]),
      .cmp_q     (cmp_q[i]),
      .flag_q    (flag_q[i]),
      .hit       (hit[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      sc_clr_q  <= '0;
      sc_stop_q <= '0;
      en_q      <= '0;
      mode_q    <= SRC_TIMER;
      width_q   <= 2'd0;
      psc_q     <= '0;
    end else begin
      if (t_clear)  cnt_q <= '0;
      else if (adv) cnt_q <= clr_hit ? '0 : cnt_nxt;

      if (t_start)                  run_q <= 1'b1;
      else if (t_stop || t_halt)    run_q <= 1'b0;
      else if (stop_hit)            run_q <= 1'b0;

      if (bus_wr) begin
        case (bus_addr)
          A_SHORT: begin
            sc_clr_q  <= bus_wdata[NCH-1:0];
            sc_stop_q <= bus_wdata[STOP_LSB +: NCH];
          end
          A_EN_SET: en_q  <= en_q | bus_wdata[EN_LSB +: NCH];
          A_EN_CLR: en_q  <= en_q & ~bus_wdata[EN_LSB +: NCH];
          A_MODE:   mode_q  <= src_e'(bus_wdata[0]);
          A_WIDTH:  width_q <= bus_wdata[1:0];
          A_PSC:    psc_q <= (bus_wdata[PSC_W-1:0] > PSC_W'(PSC_MAX)) ?
                             PSC_W'(PSC_MAX) : bus_wdata[PSC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SHORT: begin
        bus_rdata[NCH-1:0]          = sc_clr_q;
        bus_rdata[STOP_LSB +: NCH]  = sc_stop_q;
      end
      A_EN_SET, A_EN_CLR: bus_rdata[EN_LSB +: NCH] = en_q;
      A_MODE:  bus_rdata[0]        = mode_q;
      A_WIDTH: bus_rdata[1:0]      = width_q;
      A_PSC:   bus_rdata[PSC_W-1:0] = psc_q;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (bus_addr == AW'(A_FLAG0 + i)) bus_rdata[0]    = flag_q[i];
          if (bus_addr == AW'(A_CMP0 + i))  bus_rdata[CW-1:0] = cmp_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/tmr_ccu_chk.sv
module tmr_ccu_chk
  import tmr_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int CW  = CNT_W,
  parameter int AW  = ADDR_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             irq_o,
  input logic [NCH-1:0]   flag_q,
  input logic             run_q,
  input logic             stop_hit,
  input logic [PSC_W-1:0] psc_q,
  input logic [CW-1:0]    cnt_q,
  input logic [1:0]       width_q
);
  // R8: no interrupt without a raised flag
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != '0));

  // R2: stored psc never exceeds the limit
  assert_psc_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    psc_q <= PSC_W'(PSC_MAX));

  // R3: a counter update under a fixed width stays inside that width
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q) && $stable(width_q)) |-> ((cnt_q & ~cnt_mask(width_q)) == '0));

  // R7, R10: the timer only halts after a stop-type task or a stop shortcut
  assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(stop_hit) ||
      $past(bus_wr && bus_wdata == 32'd1 && (bus_addr == A_STOP || bus_addr == A_HALT))));

  // R5: a flag only falls after a zero write to its own address
  for (genvar i = 0; i < NCH; i++) begin : g_flag
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(bus_wr && bus_addr == AW'(A_FLAG0 + i) && bus_wdata == 32'd0));
  end
endmodule

bind tmr_ccu tmr_ccu_chk #(.NCH(NCH), .CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_o(irq_o), .flag_q(flag_q), .run_q(run_q),
  .stop_hit(stop_hit), .psc_q(psc_q), .cnt_q(cnt_q), .width_q(width_q)
);

// File: tb/tmr_ccu_tb_top.sv
module tmr_ccu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tmr_ccu dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  function automatic logic [31:0] wmask(input int w);
    case (w)
      0: return 32'h0000_FFFF;
      1: return 32'h0000_00FF;
      2: return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic counts(input int n);
    for (int k = 0; k < n; k++) wr(5'd2, 32'd1);
  endtask

  // capture into channel c and return the captured count
  task automatic sample(input int c, output logic [31:0] v);
    wr(5'(8 + c), 32'd1);
    rd(5'(16 + c), v);
  endtask

  task automatic timed(input int psc, input int m, output logic [31:0] v);
    do_reset();
    wr(5'd22, psc);
    wr(5'd0, 32'd1);
    repeat (m) @(posedge clk);
    wr(5'd8, 32'd1);
    wr(5'd1, 32'd1);
    rd(5'd16, v);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, en_m;
    void'($urandom(32'd4242));
    do_reset();

    // R1 reset state
    for (int a = 5; a < 23; a++) begin
      rd(5'(a), v);
      check("R1 reset register", v, 32'd0);
    end
    check("R1 reset irq", {31'd0, irq_o}, 32'd0);
    sample(0, v); check("R1 reset counter", v, 32'd0);

    // R2 tick rate, psc clamp
    timed(2, 41, v);  check("R2 psc=2 tick rate", v, 32'd10);
    timed(0, 37, v);  check("R2 psc=0 tick rate", v, 32'd37);
    timed(9, 1100, v); check("R2 psc=9 tick rate", v, 32'd2);
    wr(5'd22, 32'd15); rd(5'd22, v); check("R2 psc clamp", v, 32'd9);

    // R3 wrap in 8-bit width
    do_reset(); wr(5'd20, 1); wr(5'd21, 1);
    counts(259); sample(0, v); check("R3 8-bit wrap", v, 32'd3);

    // R4 truncation per width
    do_reset();
    wr(5'd21, 1); wr(5'd17, 32'h1234_5678); rd(5'd17, v); check("R4 width 8", v, 32'h78);
    wr(5'd21, 0); wr(5'd17, 32'h1234_5678); rd(5'd17, v); check("R4 width 16", v, 32'h5678);
    wr(5'd21, 2); wr(5'd17, 32'h1234_5678); rd(5'd17, v); check("R4 width 24", v, 32'h34_5678);
    wr(5'd21, 3); wr(5'd17, 32'h1234_5678); rd(5'd17, v); check("R4 width 32", v, 32'h1234_5678);

    // R5 sticky flag, R8 interrupt, R9 enable
    do_reset(); wr(5'd20, 1); wr(5'd16, 3);
    counts(2); rd(5'd12, v); check("R5 no flag before match", v, 0);
    counts(1); rd(5'd12, v); check("R5 flag on match", v, 1);
    check("R8 irq masked", {31'd0, irq_o}, 0);
    wr(5'd6, 32'h0001_0000); rd(5'd7, v); check("R9 enable set", v, 32'h0001_0000);
    #1 check("R8 irq on", {31'd0, irq_o}, 1);
    wr(5'd12, 1); counts(2); rd(5'd12, v); check("R5 nonzero write keeps flag", v, 1);
    wr(5'd12, 0); rd(5'd12, v); check("R5 zero write clears", v, 0);
    #1 check("R8 irq off after flag clear", {31'd0, irq_o}, 0);
    wr(5'd16, 8); counts(3); #1 check("R8 irq again", {31'd0, irq_o}, 1);
    wr(5'd7, 32'h0001_0000); #1 check("R8 R9 irq off after enable clear", {31'd0, irq_o}, 0);

    // R6 shortcut clear
    do_reset(); wr(5'd20, 1); wr(5'd16, 5); wr(5'd5, 32'h1);
    counts(5); sample(1, v); check("R6 clear on compare", v, 0);
    rd(5'd12, v); check("R6 flag set", v, 1);
    counts(3); sample(1, v); check("R6 counting resumes", v, 3);

    // R7 shortcut stop
    do_reset(); wr(5'd18, 10); wr(5'd5, 32'h400); wr(5'd0, 1);
    repeat (30) @(posedge clk);
    sample(3, v); check("R7 stop on compare", v, 10);
    rd(5'd14, v); check("R7 flag set", v, 1);

    // R10 mode gating and stop
    do_reset(); wr(5'd20, 1); wr(5'd0, 1); repeat (10) @(posedge clk);
    sample(0, v); check("R10 start ignored in counter mode", v, 0);
    do_reset(); counts(5); sample(0, v); check("R10 count ignored in timer mode", v, 0);
    do_reset(); wr(5'd0, 1); repeat (5) @(posedge clk); wr(5'd1, 1);
    sample(0, v); repeat (10) @(posedge clk); sample(1, v2);
    check("R10 stop holds count", v2, v);
    wr(5'd0, 1); repeat (5) @(posedge clk); wr(5'd4, 1);
    sample(0, v); repeat (10) @(posedge clk); sample(1, v2);
    check("R10 halt holds count", v2, v);

    // R11 clear
    do_reset(); wr(5'd20, 1); counts(7); sample(2, v); check("R11 capture", v, 7);
    wr(5'd3, 1); sample(2, v); check("R11 clear", v, 0);

    // R12 non-1 task values
    wr(5'd2, 2); sample(0, v); check("R12 count with 2 ignored", v, 0);
    wr(5'd20, 0); wr(5'd0, 3); repeat (8) @(posedge clk);
    sample(0, v); check("R12 start with 3 ignored", v, 0);

    // random: truncation R4
    do_reset();
    for (int k = 0; k < 40; k++) begin
      int w; int c; logic [31:0] d;
      w = $urandom % 4; c = $urandom % 4; d = $urandom;
      wr(5'd21, w); wr(5'(16 + c), d); rd(5'(16 + c), v);
      check("R4 random truncation", v, d & wmask(w));
    end
    // random: enable register R9
    en_m = 0;
    for (int k = 0; k < 30; k++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom % 2) begin wr(5'd6, d); en_m = en_m | (d & 32'h000F_0000); end
      else begin wr(5'd7, d); en_m = en_m & ~(d & 32'h000F_0000); end
      rd(5'(6 + ($urandom % 2)), v);
      check("R9 random enable", v, en_m);
    end
    // random: counting with wrap R3
    for (int k = 0; k < 6; k++) begin
      int w; int n;
      w = $urandom % 2; n = $urandom % 300;
      do_reset(); wr(5'd20, 1); wr(5'd21, w);
      counts(n); sample(0, v);
      check("R3 random count", v, 32'(n) & wmask(w));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule